// File: doc/BRIEF.md
# Scaled Fixed-Point System Counter

This block keeps a free-running 64-bit timestamp for a subsystem. Inside it holds an 88-bit accumulator in 64.24 fixed point: 64 integer bits on top and 24 fraction bits below. While the counter is enabled, every input clock cycle adds either one whole unit or a programmable 32-bit scale increment to the accumulator. The visible count is only the integer part. A scale value below or above one whole unit therefore makes the count advance at a non-integer ratio to the input clock.

Two 4 KB register frames give access to the counter. Each frame has its own 32-bit APB-style slave port with word addressing. The control frame holds the control bits, the writable count halves, the scale register (at two addresses), a capability word and identification bytes. The status frame gives read-only access to the count and its own identification bytes. Reads are combinational within the access. A control-frame write commits on the clock edge that ends its enable phase.

The integer part also drives a timestamp output that other blocks use directly. The asynchronous active-low reset is released through an internal two-flop synchronizer.

Top module: `sys_tstamp_counter`

## Requirements
- R1: After reset the control register reads 0, the count and the timestamp are 0, and the scale register reads 0x0100_0000.
- R2: With enable (control bit 0) set and scale enable (control bit 2) clear, the count rises by exactly 1 on each clock. With enable clear, the count holds.
- R3: With enable and scale enable both set, each clock adds the 32-bit scale value to the 88-bit accumulator. The count is the accumulator's upper 64 bits, so after n clocks from a zero accumulator it equals floor(n*scale/2^24).
- R4: The control register at byte offset 0x0 stores bits 4:0. Bits 31:5 read as zero and ignore writes.
- R5: The count low word is at 0x8 and the high word at 0xC. Both can be read and written. A write replaces only the addressed half, keeps the other half and clears the 24 fraction bits.
- R6: A count write in a cycle where an increment would also happen leaves exactly the written half. The untouched half still follows the increment.
- R7: The scale register reads and writes at 0x10 and at its alias 0xD0. Offset 0xD4 reads zero and ignores writes. Offset 0x4 always reads zero.
- R8: The capability word at 0x1C reads 0x0002_0001.
- R9: In the status frame, byte offset 0x0 reads the count low word and 0x4 the high word. Status-frame writes change nothing.
- R10: Both frames return twelve identification bytes at 0xFD0 to 0xFFC, one per word: 04,00,00,00, then BA,B0,0B,00 (control frame) or BB,B0,0B,00 (status frame), then 0D,F0,05,B1.
- R11: Any unmapped offset reads zero, and a write to it changes no register.
- R12: The timestamp output always equals the 64-bit count, including carries from the low word into the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c_psel | input | 1 | Control frame select |
| c_penable | input | 1 | Control frame access phase |
| c_pwrite | input | 1 | Control frame write when high |
| c_paddr | input | 10 | Control frame word address (byte offset bits 11:2) |
| c_pwdata | input | 32 | Control frame write data |
| c_prdata | output | 32 | Control frame read data |
| s_psel | input | 1 | Status frame select |
| s_pwrite | input | 1 | Status frame write flag (writes are ignored) |
| s_paddr | input | 10 | Status frame word address (byte offset bits 11:2) |
| s_prdata | output | 32 | Status frame read data |
| timestamp | output | 64 | Integer part of the accumulator |

## Verification
The main risk is a corrupted accumulator. A wrong increment, a stale fraction or a lost carry shows on the timestamp port at the first clock edge where it matters. It also shows one access later in either frame's count words. The bench sweeps several scale values over twenty cycles each and compares every cycle against floor(n*scale/2^24), so a one-bit fraction error shows up within a few cycles. Decode faults show up on the first read of the affected offset, and stored-state faults show up on the read-back after each write.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int WA_W    = 10;
  localparam int DATA_W  = 32;
  localparam int CTRL_W  = 5;
  localparam int BIT_EN  = 0;
  localparam int BIT_SCL = 2;

  localparam logic [WA_W-1:0] CW_CTRL  = 10'h000;
  localparam logic [WA_W-1:0] CW_STAT  = 10'h001;
  localparam logic [WA_W-1:0] CW_CLO   = 10'h002;
  localparam logic [WA_W-1:0] CW_SCALE = 10'h004;
  localparam logic [WA_W-1:0] CW_CAPS  = 10'h007;
  localparam logic [WA_W-1:0] CW_SALT  = 10'h034;
  localparam logic [WA_W-1:0] CW_SALT1 = 10'h035;
  localparam logic [WA_W-1:0] SW_CLO   = 10'h000;

  localparam logic [DATA_W-1:0] CAPS_VALUE  = 32'h0002_0001;
  localparam logic [DATA_W-1:0] SCALE_RESET = 32'h0100_0000;

  function automatic logic in_id_window(input logic [WA_W-1:0] wa);
    return (wa[WA_W-1:4] == '1) && (wa[3:2] != 2'b00);
  endfunction

  function automatic logic [7:0] id_byte(input logic status_frame,
                                         input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'h04;
      4'd4:    b = status_frame ? 8'hBB : 8'hBA;
      4'd5:    b = 8'hB0;
      4'd6:    b = 8'h0B;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/tsc_rst_sync.sv
module tsc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/tsc_accum.sv
module tsc_accum #(
  parameter int INT_W  = 64,
  parameter int FRAC_W = 24,
  parameter int SCL_W  = 32,
  parameter int HALF_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en,
  input  logic                           scl_en,
  input  logic [SCL_W-1:0]               scale,
  input  logic [INT_W/HALF_W-1:0]        wr_half,
  input  logic [HALF_W-1:0]              wdata,
  output logic [INT_W-1:0]               count
);
  localparam int ACC_W  = INT_W + FRAC_W;
  localparam int HALVES = INT_W / HALF_W;

  logic [ACC_W-1:0] acc_q, acc_d, incr;
  logic             acc_ce;

  always_comb begin
    if (scl_en) incr = {{(ACC_W-SCL_W){1'b0}}, scale};
    else        incr = {{(ACC_W-1){1'b0}}, 1'b1} << FRAC_W;
  end

  assign acc_ce = en | (|wr_half);

  always_comb begin
    acc_d = acc_q;
    if (en) acc_d = acc_q + incr;
    for (int h = 0; h < HALVES; h++) begin
      if (wr_half[h]) acc_d[FRAC_W + HALF_W*h +: HALF_W] = wdata;
    end
    if (|wr_half) acc_d[FRAC_W-1:0] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_ce) acc_q <= acc_d;
  end

  assign count = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/tsc_ctrl_frame.sv
module tsc_ctrl_frame
  import tsc_pkg::*;
#(
  parameter int INT_W  = 64,
  parameter int HALF_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  input  logic [WA_W-1:0]         paddr,
  input  logic [DATA_W-1:0]       pwdata,
  input  logic [INT_W-1:0]        count,
  output logic [DATA_W-1:0]       prdata,
  output logic                    en,
  output logic                    scl_en,
  output logic [DATA_W-1:0]       scale,
  output logic [INT_W/HALF_W-1:0] wr_half
);
  localparam int HALVES = INT_W / HALF_W;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] scale_q, scale_d;
  logic              wr_acc, rd_acc, ctrl_ce, scale_ce;
  logic [DATA_W-1:0] half_rd [HALVES];
  logic [HALVES-1:0] half_hit;

  assign wr_acc = psel & penable & pwrite;
  assign rd_acc = psel & ~pwrite;

  genvar h;
  generate
    for (h = 0; h < HALVES; h++) begin : g_half
      assign half_hit[h] = (paddr == CW_CLO + WA_W'(h));
      assign wr_half[h]  = wr_acc & half_hit[h];
      assign half_rd[h]  = count[HALF_W*h +: HALF_W];
    end
  endgenerate

  assign ctrl_ce  = wr_acc & (paddr == CW_CTRL);
  assign scale_ce = wr_acc & ((paddr == CW_SCALE) | (paddr == CW_SALT));
  assign ctrl_d   = pwdata[CTRL_W-1:0];
  assign scale_d  = pwdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ce) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        scale_q <= SCALE_RESET;
    else if (scale_ce) scale_q <= scale_d;
  end

  always_comb begin
    prdata = '0;
    if (rd_acc) begin
      if (paddr == CW_CTRL)                             prdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      else if (paddr == CW_SCALE || paddr == CW_SALT)   prdata = scale_q;
      else if (paddr == CW_CAPS)                        prdata = CAPS_VALUE;
      else if (in_id_window(paddr))                     prdata = {24'h0, id_byte(1'b0, paddr[3:0] - 4'd4)};
      else begin
        for (int k = 0; k < HALVES; k++) begin
          if (half_hit[k]) prdata = half_rd[k];
        end
      end
    end
  end

  assign en     = ctrl_q[BIT_EN];
  assign scl_en = ctrl_q[BIT_SCL];
  assign scale  = scale_q;
endmodule

// File: rtl/tsc_stat_frame.sv
module tsc_stat_frame
  import tsc_pkg::*;
#(
  parameter int INT_W  = 64,
  parameter int HALF_W = 32
) (
  input  logic              psel,
  input  logic              pwrite,
  input  logic [WA_W-1:0]   paddr,
  input  logic [INT_W-1:0]  count,
  output logic [DATA_W-1:0] prdata
);
  localparam int HALVES = INT_W / HALF_W;

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (in_id_window(paddr)) prdata = {24'h0, id_byte(1'b1, paddr[3:0] - 4'd4)};
      else begin
        for (int k = 0; k < HALVES; k++) begin
          if (paddr == SW_CLO + WA_W'(k)) prdata = count[HALF_W*k +: HALF_W];
        end
      end
    end
  end
endmodule

// File: rtl/sys_tstamp_counter.sv
module sys_tstamp_counter
  import tsc_pkg::*;
#(
  parameter int INT_W  = 64,
  parameter int FRAC_W = 24,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c_psel,
  input  logic              c_penable,
  input  logic              c_pwrite,
  input  logic [WA_W-1:0]   c_paddr,
  input  logic [DATA_W-1:0] c_pwdata,
  output logic [DATA_W-1:0] c_prdata,
  input  logic              s_psel,
  input  logic              s_pwrite,
  input  logic [WA_W-1:0]   s_paddr,
  output logic [DATA_W-1:0] s_prdata,
  output logic [INT_W-1:0]  timestamp
);
  localparam int HALVES = INT_W / HALF_W;

  logic              rst_sync_n;
  logic              ctrl_en, ctrl_scl;
  logic [DATA_W-1:0] scale;
  logic [HALVES-1:0] wr_half;
  logic [INT_W-1:0]  count;

  tsc_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tsc_ctrl_frame #(.INT_W(INT_W), .HALF_W(HALF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .psel(c_psel), .penable(c_penable), .pwrite(c_pwrite),
    .paddr(c_paddr), .pwdata(c_pwdata), .count(count),
    .prdata(c_prdata), .en(ctrl_en), .scl_en(ctrl_scl),
    .scale(scale), .wr_half(wr_half)
  );

  tsc_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W), .SCL_W(DATA_W), .HALF_W(HALF_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .en(ctrl_en), .scl_en(ctrl_scl),
    .scale(scale), .wr_half(wr_half), .wdata(c_pwdata[HALF_W-1:0]),
    .count(count)
  );

  tsc_stat_frame #(.INT_W(INT_W), .HALF_W(HALF_W)) u_stat (
    .psel(s_psel), .pwrite(s_pwrite), .paddr(s_paddr),
    .count(count), .prdata(s_prdata)
  );

  assign timestamp = count;
endmodule

// File: rtl/sys_tstamp_counter_chk.sv
module sys_tstamp_counter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        scl,
  input logic        c_psel,
  input logic        c_penable,
  input logic        c_pwrite,
  input logic [9:0]  c_paddr,
  input logic [31:0] c_pwdata,
  input logic [31:0] c_prdata,
  input logic        s_psel,
  input logic        s_pwrite,
  input logic [9:0]  s_paddr,
  input logic [31:0] s_prdata,
  input logic [63:0] timestamp
);
  logic cnt_wr;
  assign cnt_wr = c_psel & c_penable & c_pwrite & ((c_paddr == 10'h002) | (c_paddr == 10'h003));

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(timestamp));

  // R2
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !scl && !cnt_wr) |=> (timestamp == $past(timestamp) + 64'd1));

  // R6
  low_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_psel && c_penable && c_pwrite && c_paddr == 10'h002 && !en) |=>
      (timestamp == {$past(timestamp[63:32]), $past(c_pwdata)}));

  // R4
  ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_psel && !c_pwrite && c_paddr == 10'h000) |-> (c_prdata[31:5] == 27'h0));

  // R8
  caps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_psel && !c_pwrite && c_paddr == 10'h007) |-> (c_prdata == 32'h0002_0001));

  // R9
  status_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_psel && !s_pwrite && s_paddr == 10'h000) |-> (s_prdata == timestamp[31:0]));
endmodule

bind sys_tstamp_counter sys_tstamp_counter_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .en(ctrl_en), .scl(ctrl_scl),
  .c_psel(c_psel), .c_penable(c_penable), .c_pwrite(c_pwrite),
  .c_paddr(c_paddr), .c_pwdata(c_pwdata), .c_prdata(c_prdata),
  .s_psel(s_psel), .s_pwrite(s_pwrite), .s_paddr(s_paddr),
  .s_prdata(s_prdata), .timestamp(timestamp)
);

// File: tb/tb_sys_tstamp_counter.sv
module tb_sys_tstamp_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        c_psel = 0, c_penable = 0, c_pwrite = 0;
  logic [9:0]  c_paddr = '0;
  logic [31:0] c_pwdata = '0;
  logic [31:0] c_prdata;
  logic        s_psel = 0, s_pwrite = 0;
  logic [9:0]  s_paddr = '0;
  logic [31:0] s_prdata;
  logic [63:0] timestamp;

  int n_chk = 0;
  int n_fail = 0;

  sys_tstamp_counter dut (
    .clk(clk), .rst_n(rst_n),
    .c_psel(c_psel), .c_penable(c_penable), .c_pwrite(c_pwrite),
    .c_paddr(c_paddr), .c_pwdata(c_pwdata), .c_prdata(c_prdata),
    .s_psel(s_psel), .s_pwrite(s_pwrite), .s_paddr(s_paddr),
    .s_prdata(s_prdata), .timestamp(timestamp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic cwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    c_psel = 1; c_pwrite = 1; c_penable = 0; c_paddr = a[11:2]; c_pwdata = d;
    @(negedge clk);
    c_penable = 1;
    @(negedge clk);
    c_psel = 0; c_penable = 0; c_pwrite = 0;
  endtask

  task automatic crd(input logic [11:0] a, output logic [31:0] d);
    c_psel = 1; c_pwrite = 0; c_penable = 1; c_paddr = a[11:2];
    #1;
    d = c_prdata;
    c_psel = 0; c_penable = 0;
  endtask

  task automatic srd(input logic [11:0] a, output logic [31:0] d);
    s_psel = 1; s_pwrite = 0; s_paddr = a[11:2];
    #1;
    d = s_prdata;
    s_psel = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [87:0] prod;
    logic [31:0] scales [7];
    scales = '{32'h0100_0000, 32'h0080_0000, 32'h0180_0000, 32'h0055_5555,
               32'h0300_0000, 32'h0000_0001, 32'hFFFF_FFFF};

    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    crd(12'h000, r); chk("R1 ctrl", r, 0);
    crd(12'h010, r); chk("R1 scale", r, 32'h0100_0000);
    crd(12'h008, r); chk("R1 count lo", r, 0);
    chk("R1 timestamp", timestamp, 0);
    // R7 status word and second scale slot
    crd(12'h004, r); chk("R7 status zero", r, 0);
    crd(12'h0D4, r); chk("R7 d4 zero", r, 0);
    // R8
    crd(12'h01C, r); chk("R8 caps", r, 32'h0002_0001);

    // R10 id bytes, both frames
    for (int i = 0; i < 12; i++) begin
      logic [7:0] e;
      case (i)
        0: e = 8'h04; 4: e = 8'hBA; 5: e = 8'hB0; 6: e = 8'h0B;
        8: e = 8'h0D; 9: e = 8'hF0; 10: e = 8'h05; 11: e = 8'hB1;
        default: e = 8'h00;
      endcase
      crd(12'hFD0 + 12'(4*i), r); chk("R10 ctrl id", r, {24'h0, e});
      srd(12'hFD0 + 12'(4*i), r); chk("R10 stat id", r, {24'h0, (i == 4) ? 8'hBB : e});
    end

    // R4 reserved control bits
    cwr(12'h000, 32'hFFFF_FFFA);
    crd(12'h000, r); chk("R4 ctrl mask", r, 32'h1A);
    cwr(12'h000, 32'h0);

    // R7 alias
    cwr(12'h0D0, 32'h0123_4567);
    crd(12'h010, r); chk("R7 alias 10", r, 32'h0123_4567);
    cwr(12'h010, 32'h0200_0000);
    crd(12'h0D0, r); chk("R7 alias d0", r, 32'h0200_0000);
    cwr(12'h0D4, 32'hFFFF_FFFF);
    crd(12'h0D4, r); chk("R7 d4 write ignored", r, 0);
    crd(12'h010, r); chk("R7 scale after d4 write", r, 32'h0200_0000);

    // R11 unmapped
    cwr(12'h020, 32'hFFFF_FFFF);
    cwr(12'h800, 32'hFFFF_FFFF);
    crd(12'h020, r); chk("R11 unmapped read", r, 0);
    crd(12'h800, r); chk("R11 unmapped read hi", r, 0);
    crd(12'h000, r); chk("R11 ctrl intact", r, 0);
    crd(12'h010, r); chk("R11 scale intact", r, 32'h0200_0000);
    srd(12'h100, r); chk("R11 status unmapped", r, 0);

    // R5 half writes
    cwr(12'h008, 32'hDEAD_BEEF);
    cwr(12'h00C, 32'h0000_1234);
    crd(12'h008, r); chk("R5 lo kept", r, 32'hDEAD_BEEF);
    crd(12'h00C, r); chk("R5 hi", r, 32'h0000_1234);
    cwr(12'h008, 32'h0000_0042);
    chk("R5 hi kept", timestamp, 64'h1234_0000_0042);

    // R9 status view and ignored writes
    srd(12'h000, r); chk("R9 stat lo", r, 32'h42);
    srd(12'h004, r); chk("R9 stat hi", r, 32'h1234);
    @(negedge clk);
    s_psel = 1; s_pwrite = 1; s_paddr = 10'h000;
    repeat (3) @(negedge clk);
    s_psel = 0; s_pwrite = 0;
    chk("R9 stat write ignored", timestamp, 64'h1234_0000_0042);

    // R2 hold when disabled
    repeat (5) @(negedge clk);
    chk("R2 hold disabled", timestamp, 64'h1234_0000_0042);

    // R12 carry across halves
    cwr(12'h008, 32'hFFFF_FFFE);
    cwr(12'h00C, 32'h5);
    cwr(12'h000, 32'h1);
    repeat (3) @(negedge clk);
    chk("R12 carry", timestamp, 64'h6_0000_0001);
    crd(12'h00C, r); chk("R12 hi read", r, 32'h6);

    // R6 write wins while running
    cwr(12'h008, 32'h100);
    chk("R6 lo write wins", timestamp, 64'h6_0000_0100);
    cwr(12'h00C, 32'h77);
    chk("R6 hi write wins", timestamp, 64'h77_0000_0103);

    // R5 fraction cleared by count write
    cwr(12'h000, 32'h0);
    cwr(12'h008, 32'h0);
    cwr(12'h00C, 32'h0);
    cwr(12'h010, 32'h0080_0000);
    cwr(12'h000, 32'h5);
    cwr(12'h000, 32'h0);
    chk("R3 half scale 3 steps", timestamp, 64'h1);
    cwr(12'h008, 32'h0);
    cwr(12'h000, 32'h5);
    @(negedge clk);
    chk("R5 fraction cleared", timestamp, 64'h0);
    @(negedge clk);
    chk("R5 fraction then whole", timestamp, 64'h1);

    // R3 / R2 sweep over scale values, scaling on and off
    for (int s = 0; s < 7; s++) begin
      for (int m = 0; m < 2; m++) begin
        cwr(12'h000, 32'h0);
        cwr(12'h008, 32'h0);
        cwr(12'h00C, 32'h0);
        cwr(12'h010, scales[s]);
        cwr(12'h000, (m == 1) ? 32'h5 : 32'h1);
        for (int n = 1; n <= 20; n++) begin
          @(negedge clk);
          prod = 88'(n) * ((m == 1) ? 88'(scales[s]) : 88'h100_0000);
          if (m == 1) chk("R3 scaled sweep", timestamp, prod[87:24]);
          else        chk("R2 unscaled sweep", timestamp, prod[87:24]);
        end
        srd(12'h000, r); chk("R12 status matches output", r, timestamp[31:0]);
      end
    end

    finish_run();
  end
endmodule